// File: doc/BRIEF.md
# Multi-channel periodic interrupt timer

A bank of independent 32-bit down counters placed behind a single-cycle register port. Each channel is armed by software with a period value. The channel counts towards zero. On the cycle after it reaches zero it reloads that value, raises a sticky event flag and keeps running, so every channel is free-running and periodic. A channel can also be set to advance only when its lower-indexed neighbour expires. Two channels linked in this way act as one 64-bit timer.

Software uses the block through the bus alone. A global halt bit gates all counting and resets to the halted state. Each channel has four words: the period value, the live count, a control word and the event flag. Each channel drives one interrupt line, which is the flag qualified by that channel's interrupt enable.

Top module: `tick_array`

## Requirements
- R1: After reset the global control word reads 0x2 (halt set) and every channel word reads 0; all interrupt lines are low.
- R2: While the halt bit (bit 1 of the word at 0x000) is 1, no count changes. Setting a channel's run bit still copies its period value into the count.
- R3: Writing the run bit (control bit 0) from 0 to 1 copies the period value into the count on that write's clock edge. While running and not halted, the count then falls by one every clock, and a read of the count word returns the live value.
- R4: A running channel with period value P reaches zero P cycles after arming. On the following edge it reloads P and sets its event flag, so events repeat every P+1 cycles.
- R5: Writing the period value while the channel runs leaves the current count untouched. The new value is used at the next reload or at the next re-arm.
- R6: Clearing the run bit freezes the count at its current value.
- R7: The event flag (flag word bit 0) is sticky. Writing 1 to that bit clears it, and writing 0 has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R8: Interrupt line n is high exactly when channel n's flag and its interrupt-enable (control bit 1) are both 1. A flag raised while the enable is 0 is kept, and it drives the line once the enable is set.
- R9: With the link bit (control bit 2) set on channel n>0, the count falls only on cycles in which channel n-1 expires. On channel 0 the link bit is stored but counting stays per clock.
- R10: Channel n's words sit at 0x100+0x10*n: period at +0x0, count at +0x4, control at +0x8, flag at +0xC. Control reads back as {link, irq-enable, run} in bits 2..0. Reads of unmapped addresses return 0.
- R11: Read data is registered: it appears on the clock edge after the address is presented and reflects the state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | CNT_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | CNT_W | Registered read data for the previous cycle's address |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
A write lands on the next edge. A read returns, one edge after its address, the state that held just before that edge. An armed count is therefore visible in the cycle after the arming write, and the first event flag appears P+1 cycles after that write. A linked channel moves one edge after the cycle in which its neighbour sits at zero. The bench keeps a cycle counter and stamps every expected read with the cycle in which the result is due. A monitor compares each stamped item at that cycle's falling edge, and every stimulus is placed on an absolute cycle computed from the arming write.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam logic [1:0] SEL_LOAD  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_FLAG  = 2'd3;
  localparam int BIT_HALT = 1;
  localparam int BIT_EVT  = 0;

  typedef struct packed {
    logic link;
    logic ie;
    logic run;
  } chan_ctrl_t;
endpackage

// File: rtl/tick_decode.sv
module tick_decode
  import tick_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 12,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              top_hit,
  output logic              bank_hit,
  output logic [IDX_W-1:0]  ch,
  output logic [1:0]        sel
);
  always_comb begin
    top_hit  = (addr == '0);
    bank_hit = (addr[ADDR_W-1:8] == (ADDR_W-8)'(1)) &&
               (addr[1:0] == 2'b00) &&
               (int'(addr[7:4]) < NCH);
    ch       = addr[4 +: IDX_W];
    sel      = addr[3:2];
  end
endmodule

// File: rtl/tick_channel.sv
module tick_channel
  import tick_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic             wr_ld,
  input  logic             wr_ctrl,
  input  logic             wr_flag,
  input  logic [CNT_W-1:0] wdata,
  input  logic             prev_exp,
  output logic [CNT_W-1:0] ld_q,
  output logic [CNT_W-1:0] cnt_q,
  output chan_ctrl_t       ctrl_q,
  output logic             flag_q,
  output logic             exp_o,
  output logic             irq_o
);
  localparam bit HEAD = (IDX == 0);

  logic start, run, step, tick, clr;

  assign start = wr_ctrl && wdata[0] && !ctrl_q.run;
  assign run   = ctrl_q.run && !halt;
  assign step  = !ctrl_q.link || HEAD || prev_exp;
  assign tick  = run && step;
  assign exp_o = tick && (cnt_q == '0);
  assign clr   = wr_flag && wdata[BIT_EVT];
  assign irq_o = flag_q && ctrl_q.ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q   <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ld)   ld_q   <= wdata;
      if (wr_ctrl) ctrl_q <= chan_ctrl_t'(wdata[2:0]);
      if (start)      cnt_q <= ld_q;
      else if (tick)  cnt_q <= exp_o ? ld_q : cnt_q - CNT_W'(1);
      if (exp_o)      flag_q <= 1'b1;
      else if (clr)   flag_q <= 1'b0;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> $stable(cnt_q)); // R6
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R3
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    exp_o |=> (cnt_q == $past(ld_q) && flag_q)); // R4
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q); // R7

  if (IDX > 0) begin : g_link_chk
    AST_LINK_WAIT: assert property (@(posedge clk) disable iff (rst)
      (run && ctrl_q.link && !prev_exp && !start) |=> $stable(cnt_q)); // R9
  end
endmodule

// File: rtl/tick_rdmux.sv
module tick_rdmux
  import tick_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 32,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      top_hit,
  input  logic                      bank_hit,
  input  logic [IDX_W-1:0]          ch,
  input  logic [1:0]                sel,
  input  logic                      halt,
  input  logic [NCH-1:0][CNT_W-1:0] ld_all,
  input  logic [NCH-1:0][CNT_W-1:0] cnt_all,
  input  chan_ctrl_t [NCH-1:0]      ctrl_all,
  input  logic [NCH-1:0]            flag_all,
  output logic [CNT_W-1:0]          rdata
);
  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (top_hit) begin
      nxt[BIT_HALT] = halt;
    end else if (bank_hit) begin
      case (sel)
        SEL_LOAD:  nxt = ld_all[ch];
        SEL_COUNT: nxt = cnt_all[ch];
        SEL_CTRL:  nxt = CNT_W'(ctrl_all[ch]);
        default:   nxt = CNT_W'(flag_all[ch]);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end
endmodule

// File: rtl/tick_array.sv
module tick_array
  import tick_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    irq
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic                      top_hit, bank_hit;
  logic [IDX_W-1:0]          ch;
  logic [1:0]                sel;
  logic                      halt_q;
  logic [NCH-1:0][CNT_W-1:0] ld_all, cnt_all;
  chan_ctrl_t [NCH-1:0]      ctrl_all;
  logic [NCH-1:0]            flag_all, exp_all;
  logic [NCH-1:0]            wr_ld_v, wr_ctrl_v, wr_flag_v;

  tick_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_decode (
    .addr(bus_addr), .top_hit(top_hit), .bank_hit(bank_hit), .ch(ch), .sel(sel)
  );

  always_ff @(posedge clk) begin
    if (rst)                     halt_q <= 1'b1;
    else if (bus_we && top_hit)  halt_q <= bus_wdata[BIT_HALT];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic prev;
    logic mine;
    if (i == 0) begin : g_head
      assign prev = 1'b0;
    end else begin : g_next
      assign prev = exp_all[i-1];
    end
    assign mine         = bus_we && bank_hit && (ch == IDX_W'(i));
    assign wr_ld_v[i]   = mine && (sel == SEL_LOAD);
    assign wr_ctrl_v[i] = mine && (sel == SEL_CTRL);
    assign wr_flag_v[i] = mine && (sel == SEL_FLAG);

    tick_channel #(.CNT_W(CNT_W), .IDX(i)) u_chan (
      .clk(clk), .rst(rst), .halt(halt_q),
      .wr_ld(wr_ld_v[i]), .wr_ctrl(wr_ctrl_v[i]), .wr_flag(wr_flag_v[i]),
      .wdata(bus_wdata), .prev_exp(prev),
      .ld_q(ld_all[i]), .cnt_q(cnt_all[i]), .ctrl_q(ctrl_all[i]),
      .flag_q(flag_all[i]), .exp_o(exp_all[i]), .irq_o(irq[i])
    );
  end

  tick_rdmux #(.NCH(NCH), .CNT_W(CNT_W)) u_rdmux (
    .clk(clk), .rst(rst), .top_hit(top_hit), .bank_hit(bank_hit), .ch(ch),
    .sel(sel), .halt(halt_q), .ld_all(ld_all), .cnt_all(cnt_all),
    .ctrl_all(ctrl_all), .flag_all(flag_all), .rdata(bus_rdata)
  );

  AST_HALT_STILL: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !bus_we) |=> $stable(cnt_all)); // R2
  AST_HALT_NO_EVT: assert property (@(posedge clk) disable iff (rst)
    halt_q |-> (exp_all == '0)); // R2
endmodule

// File: tb/tick_array_bench.sv
`timescale 1ns/1ps
module tick_array_bench;
  localparam int NCH = 4, CNT_W = 32, ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [CNT_W-1:0]  bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic [CNT_W-1:0]  bus_rdata;
  logic [NCH-1:0]    irq;

  always #2 clk = ~clk;

  tick_array #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_tick_array (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    logic [CNT_W-1:0]  exp;
    int                due;
    string             req;
    logic [ADDR_W-1:0] addr;
  } rd_item_t;

  rd_item_t sb_q[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each expected read in the cycle it is due
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      n_chk++;
      if (bus_rdata !== sb_q[0].exp) begin
        n_fail++;
        $display("FAIL %s addr=%h actual=%h expected=%h",
                 sb_q[0].req, sb_q[0].addr, bus_rdata, sb_q[0].exp);
      end
      void'(sb_q.pop_front());
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] e,
                    input string r);
    rd_item_t it;
    it.exp = e; it.due = cyc + 1; it.req = r; it.addr = a;
    bus_addr = a;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic chk_irq(input int idx, input bit e, input string r);
    n_chk++;
    if (irq[idx] !== e) begin
      n_fail++;
      $display("FAIL %s irq[%0d] actual=%b expected=%b", r, idx, irq[idx], e);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int k, a, c, d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R11: reset values, registered read path
    rd(12'h000, 32'h2, "R1 R11");
    rd(12'h104, 32'h0, "R1");
    rd(12'h138, 32'h0, "R1");
    rd(12'h10C, 32'h0, "R1");
    for (int i = 0; i < NCH; i++) chk_irq(i, 1'b0, "R1");

    // R2: halted, arming copies the period but nothing counts
    wr(12'h120, 32'd5);
    wr(12'h128, 32'h1);
    repeat (6) @(negedge clk);
    rd(12'h124, 32'd5, "R2");

    // release halt
    wr(12'h000, 32'h0);
    rd(12'h000, 32'h0, "R10");

    // R3 R4 R8 R7 on channel 0, link bit set (R9: no effect on channel 0)
    wr(12'h100, 32'd100);
    k = cyc;
    wr(12'h108, 32'h5);
    rd(12'h104, 32'd100, "R3 R11");
    rd(12'h104, 32'd99, "R3 R9");
    idle_to(k + 101);
    rd(12'h10C, 32'h0, "R4");
    rd(12'h10C, 32'h1, "R4");
    chk_irq(0, 1'b0, "R8");
    wr(12'h108, 32'h7);
    chk_irq(0, 1'b1, "R8");
    wr(12'h10C, 32'h0);
    chk_irq(0, 1'b1, "R7");
    wr(12'h10C, 32'h1);
    chk_irq(0, 1'b0, "R7");
    rd(12'h10C, 32'h0, "R7");
    rd(12'h108, 32'h7, "R10");

    // R5 R6 on channel 1
    wr(12'h110, 32'd9);
    a = cyc;
    wr(12'h118, 32'h1);
    idle_to(a + 3);
    wr(12'h110, 32'd4);
    rd(12'h114, 32'd6, "R5");
    idle_to(a + 11);
    rd(12'h114, 32'd4, "R5");
    wr(12'h118, 32'h0);
    rd(12'h114, 32'd2, "R6");
    idle_to(a + 30);
    rd(12'h114, 32'd2, "R6");
    rd(12'h11C, 32'h1, "R4");
    c = cyc;
    wr(12'h118, 32'h1);
    rd(12'h114, 32'd4, "R5");
    if (cyc != c + 2) begin n_chk++; n_fail++; $display("FAIL R5 timing actual=%0d expected=%0d", cyc, c + 2); end

    // R9: channel 3 linked to channel 2
    wr(12'h128, 32'h0);
    wr(12'h138, 32'h0);
    wr(12'h130, 32'd2);
    d = cyc;
    wr(12'h138, 32'h5);
    wr(12'h128, 32'h1);
    idle_to(d + 7);
    rd(12'h134, 32'd2, "R9");
    rd(12'h134, 32'd1, "R9");
    idle_to(d + 19);
    rd(12'h13C, 32'h0, "R9");
    rd(12'h13C, 32'h1, "R9");
    chk_irq(3, 1'b0, "R8");
    rd(12'h138, 32'h5, "R10");

    // R10: unmapped addresses
    rd(12'h0F0, 32'h0, "R10");
    rd(12'h140, 32'h0, "R10");
    rd(12'h004, 32'h0, "R10");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R11 pending reads actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule